// File: doc/BRIEF.md
# Time-Sync Timestamp Event Unit

This block keeps a free-running 32-bit time counter clocked by the reference clock. It records timestamped events in a 16-entry queue that software reads through a small word-addressed register interface. Software can start and stop the counter, load it with a new value, and ask for a snapshot of the current count. Every event becomes one queue entry. The entry's low word is the counter value and its high word is a descriptor holding the event kind, a 4-bit message type and a 16-bit sequence number.

Event sources:
- the software snapshot command;
- full wraps of the counter;
- half wraps, where bit 31 rises;
- four external strobe lanes;
- network receive and transmit strobes, which arrive with a message type and sequence number.

Logging both wrap kinds lets software extend the count beyond 32 bits. It also tells software whether a timestamp read late was taken before or after a wrap. A level interrupt stays raised while the queue holds an entry and the interrupt is enabled. Software removes the oldest entry by writing the pop register.

Top module: `tstamp_evt_unit`

## Requirements
- R1: Register map, by byte offset:
  - 0x00 reads 0x4E8A0101.
  - Control (0x04), reference-select (0x08), load-value (0x10) and interrupt-enable (0x28) read back what was written; after reset they read 0.
  - Command registers (0x0C push, 0x14 load, 0x30 pop) and unmapped offsets read 0.
  - Raw status is at 0x20, masked status at 0x24, the oldest entry's low word at 0x34 and its high word at 0x38.
- R2: While control bit 0 is 1 the counter increments by one every cycle; while it is 0 the counter holds. Writing 1 to bit 0 of 0x14 copies the load-value register into the counter, whether or not the counter runs.
- R3: With the counter running, writing 1 to bit 0 of 0x0C queues a kind-0 event whose low word is the counter value in the cycle of the write.
- R4: The counter may step from 0xFFFFFFFF to 0 by counting, not by a load. That step queues a kind-1 event with low word 0. A counting step from 0x7FFFFFFF to 0x80000000 queues a kind-2 event with low word 0x80000000.
- R5: A strobe on external lane k queues a kind-3 event with message type 0, sequence number k, and the counter value of the strobe cycle.
- R6: A receive strobe queues a kind-4 event and a transmit strobe queues a kind-5 event. Each carries the message type and sequence number presented with the strobe, and the counter value of the strobe cycle.
- R7: Event high word layout: bits 31:24 are 0, bits 23:20 the kind, bits 19:16 the message type, bits 15:0 the sequence number.
- R8: Events raised in the same cycle are queued in this order: full wrap, half wrap, software push, lanes 0 to 3, receive, transmit.
- R9: Raw status bit 0 is 1 exactly while the queue is non-empty. Offsets 0x34 and 0x38 show the oldest entry, and read 0 when the queue is empty.
- R10: Writing 1 to bit 0 of 0x30 removes the oldest entry. A pop on an empty queue changes nothing.
- R11: Masked status bit 0 and the irq output both equal raw status bit 0 AND interrupt-enable bit 0.
- R12: Overflow handling:
  - An event that finds 16 entries queued, counting entries added earlier in the same cycle, is dropped. A pop in the same cycle does not make room.
  - A drop sets raw status bit 1, which stays set until 1 is written to bit 1 of 0x20.
  - If a drop and that clear happen in the same cycle, the flag stays set.
- R13: While control bit 0 is 0, no source queues an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_stb | input | 4 | External timestamp strobes, one per lane |
| rx_stb | input | 1 | Receive event strobe |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence number |
| tx_stb | input | 1 | Transmit event strobe |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence number |
| irq | output | 1 | Level interrupt |

## Verification
The bench loads values just below each wrap point. A design that misdetects wraps, or stamps the wrong value, shows a missing or mis-stamped kind-1 or kind-2 entry.

It fires every source in one cycle and pops the entries in turn. A wrong priority order, or a wrong pointer offset when several entries are written at once, shows up as high words in the wrong order.

It overfills the queue with a pop in the same cycle as a drop. A design that frees a slot early keeps 16 entries instead of 15, or misses the sticky flag. It also pops an empty queue and then checks that the next entry is still read correctly.

A random phase compares every head, status bit and irq against a reference queue model.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
    localparam int TS_W   = 32;
    localparam int MSG_W  = 4;
    localparam int SEQ_W  = 16;
    localparam int KIND_W = 4;
    localparam int AW     = 8;

    localparam logic [31:0] UNIT_ID = 32'h4E8A0101;

    localparam logic [AW-1:0] A_ID     = 8'h00;
    localparam logic [AW-1:0] A_CTRL   = 8'h04;
    localparam logic [AW-1:0] A_REFSEL = 8'h08;
    localparam logic [AW-1:0] A_PUSH   = 8'h0C;
    localparam logic [AW-1:0] A_LDVAL  = 8'h10;
    localparam logic [AW-1:0] A_LDEN   = 8'h14;
    localparam logic [AW-1:0] A_RAW    = 8'h20;
    localparam logic [AW-1:0] A_MASKED = 8'h24;
    localparam logic [AW-1:0] A_IEN    = 8'h28;
    localparam logic [AW-1:0] A_POP    = 8'h30;
    localparam logic [AW-1:0] A_EVLO   = 8'h34;
    localparam logic [AW-1:0] A_EVHI   = 8'h38;

    typedef enum logic [KIND_W-1:0] {
        EV_PUSH  = 4'd0,
        EV_WRAP  = 4'd1,
        EV_HALF  = 4'd2,
        EV_HWSTB = 4'd3,
        EV_RX    = 4'd4,
        EV_TX    = 4'd5
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e              kind;
        logic [MSG_W-1:0]      msg;
        logic [SEQ_W-1:0]      seq;
        logic [TS_W-1:0]       ts;
    } ev_rec_t;

    function automatic ev_rec_t mk_rec(ev_kind_e k, logic [MSG_W-1:0] m,
                                       logic [SEQ_W-1:0] s, logic [TS_W-1:0] t);
        ev_rec_t r;
        r.kind = k;
        r.msg  = m;
        r.seq  = s;
        r.ts   = t;
        return r;
    endfunction

    // descriptor word: zero pad, kind, message type, sequence number
    function automatic logic [31:0] hi_word(ev_rec_t r);
        return {8'd0, r.kind, r.msg, r.seq};
    endfunction
endpackage

// File: rtl/tstamp_counter.sv
module tstamp_counter
    import tstamp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    output logic [TS_W-1:0] cnt,
    output logic            wrap_hit,
    output logic            half_hit
);
    localparam logic [TS_W-1:0] ALL_ONES = '1;
    localparam logic [TS_W-1:0] HALF_M1  = {1'b0, {(TS_W-1){1'b1}}};

    // wrap events only come from counting; a load in the same cycle wins
    assign wrap_hit = run && !load && (cnt == ALL_ONES);
    assign half_hit = run && !load && (cnt == HALF_M1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (run)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tstamp_evt_src.sv
module tstamp_evt_src
    import tstamp_pkg::*;
#(
    parameter int N_HW  = 4,
    parameter int N_SRC = N_HW + 5
) (
    input  logic             run,
    input  logic             push,
    input  logic             wrap_hit,
    input  logic             half_hit,
    input  logic [N_HW-1:0]  hw_stb,
    input  logic             rx_stb,
    input  logic [MSG_W-1:0] rx_msg,
    input  logic [SEQ_W-1:0] rx_seq,
    input  logic             tx_stb,
    input  logic [MSG_W-1:0] tx_msg,
    input  logic [SEQ_W-1:0] tx_seq,
    input  logic [TS_W-1:0]  cnt,
    output logic [N_SRC-1:0] vld,
    output ev_rec_t          rec [N_SRC]
);
    localparam int RX_IDX = N_HW + 3;
    localparam int TX_IDX = N_HW + 4;
    localparam logic [TS_W-1:0] HALF_TS = {1'b1, {(TS_W-1){1'b0}}};

    // slot index is the enqueue priority
    assign vld[0] = wrap_hit;
    assign rec[0] = mk_rec(EV_WRAP, '0, '0, '0);
    assign vld[1] = half_hit;
    assign rec[1] = mk_rec(EV_HALF, '0, '0, HALF_TS);
    assign vld[2] = run && push;
    assign rec[2] = mk_rec(EV_PUSH, '0, '0, cnt);

    for (genvar k = 0; k < N_HW; k++) begin : g_lane
        assign vld[3+k] = run && hw_stb[k];
        assign rec[3+k] = mk_rec(EV_HWSTB, '0, SEQ_W'(k), cnt);
    end

    assign vld[RX_IDX] = run && rx_stb;
    assign rec[RX_IDX] = mk_rec(EV_RX, rx_msg, rx_seq, cnt);
    assign vld[TX_IDX] = run && tx_stb;
    assign rec[TX_IDX] = mk_rec(EV_TX, tx_msg, tx_seq, cnt);
endmodule

// File: rtl/tstamp_evt_fifo.sv
module tstamp_evt_fifo
    import tstamp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int N_IN  = 9,
    parameter int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  in_vld,
    input  ev_rec_t          in_rec [N_IN],
    input  logic             pop,
    output ev_rec_t          head,
    output logic             nonempty,
    output logic [LVL_W-1:0] level,
    output logic             drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + N_IN + 1);

    ev_rec_t         mem [DEPTH];
    logic [PW-1:0]   rd_ptr;
    logic [PW-1:0]   wr_ptr;
    logic [N_IN-1:0] take;
    logic [PW-1:0]   slot [N_IN];
    logic [CW-1:0]   n_take;
    logic            do_pop;

    // compact same-cycle writers in index order; space is judged before any pop
    always_comb begin
        n_take = '0;
        take   = '0;
        drop   = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            slot[i] = wr_ptr + PW'(n_take);
            if (in_vld[i]) begin
                if (CW'(level) + n_take < CW'(DEPTH)) begin
                    take[i] = 1'b1;
                    n_take  = n_take + 1'b1;
                end else begin
                    drop = 1'b1;
                end
            end
        end
    end

    assign nonempty = (level != '0);
    assign do_pop   = pop && nonempty;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_IN; i++) begin
            if (take[i]) mem[slot[i]] <= in_rec[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(n_take);
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            level <= level + LVL_W'(n_take) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/tstamp_evt_unit.sv
module tstamp_evt_unit
    import tstamp_pkg::*;
#(
    parameter int N_HW       = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int REFSEL_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [N_HW-1:0]  hw_stb,
    input  logic             rx_stb,
    input  logic [MSG_W-1:0] rx_msg,
    input  logic [SEQ_W-1:0] rx_seq,
    input  logic             tx_stb,
    input  logic [MSG_W-1:0] tx_msg,
    input  logic [SEQ_W-1:0] tx_seq,
    output logic             irq
);
    localparam int N_SRC  = N_HW + 5;
    localparam int FLVL_W = $clog2(FIFO_DEPTH) + 1;

    logic                run_q, ien_q, ovf_q;
    logic [REFSEL_W-1:0] refsel_q;
    logic [TS_W-1:0]     ldval_q;
    logic [TS_W-1:0]     cnt_q;
    logic                push_req, ld_req, pop_req, ovf_clr;
    logic                wrap_hit, half_hit;
    logic [N_SRC-1:0]    src_vld;
    ev_rec_t             src_rec [N_SRC];
    ev_rec_t             head;
    logic                fifo_nempty, fifo_drop;
    logic [FLVL_W-1:0]   fifo_level;

    function automatic logic wr_at(logic [AW-1:0] a, logic [AW-1:0] target, logic we);
        return we && (a == target);
    endfunction

    assign push_req = wr_at(bus_addr, A_PUSH, bus_wr) && bus_wdata[0];
    assign ld_req   = wr_at(bus_addr, A_LDEN, bus_wr) && bus_wdata[0];
    assign pop_req  = wr_at(bus_addr, A_POP,  bus_wr) && bus_wdata[0];
    assign ovf_clr  = wr_at(bus_addr, A_RAW,  bus_wr) && bus_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            ien_q    <= 1'b0;
            ovf_q    <= 1'b0;
            refsel_q <= '0;
            ldval_q  <= '0;
        end else begin
            if (wr_at(bus_addr, A_CTRL, bus_wr))   run_q    <= bus_wdata[0];
            if (wr_at(bus_addr, A_IEN, bus_wr))    ien_q    <= bus_wdata[0];
            if (wr_at(bus_addr, A_REFSEL, bus_wr)) refsel_q <= bus_wdata[REFSEL_W-1:0];
            if (wr_at(bus_addr, A_LDVAL, bus_wr))  ldval_q  <= bus_wdata;
            // a drop in the same cycle outranks the clear
            if (fifo_drop)    ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    tstamp_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (run_q),
        .load     (ld_req),
        .load_val (ldval_q),
        .cnt      (cnt_q),
        .wrap_hit (wrap_hit),
        .half_hit (half_hit)
    );

    tstamp_evt_src #(.N_HW(N_HW), .N_SRC(N_SRC)) u_src (
        .run      (run_q),
        .push     (push_req),
        .wrap_hit (wrap_hit),
        .half_hit (half_hit),
        .hw_stb   (hw_stb),
        .rx_stb   (rx_stb),
        .rx_msg   (rx_msg),
        .rx_seq   (rx_seq),
        .tx_stb   (tx_stb),
        .tx_msg   (tx_msg),
        .tx_seq   (tx_seq),
        .cnt      (cnt_q),
        .vld      (src_vld),
        .rec      (src_rec)
    );

    tstamp_evt_fifo #(.DEPTH(FIFO_DEPTH), .N_IN(N_SRC), .LVL_W(FLVL_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (src_vld),
        .in_rec   (src_rec),
        .pop      (pop_req),
        .head     (head),
        .nonempty (fifo_nempty),
        .level    (fifo_level),
        .drop     (fifo_drop)
    );

    assign irq = fifo_nempty && ien_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_ID:     bus_rdata = UNIT_ID;
            A_CTRL:   bus_rdata[0] = run_q;
            A_REFSEL: bus_rdata[REFSEL_W-1:0] = refsel_q;
            A_LDVAL:  bus_rdata = ldval_q;
            A_RAW:    bus_rdata[1:0] = {ovf_q, fifo_nempty};
            A_MASKED: bus_rdata[0] = fifo_nempty && ien_q;
            A_IEN:    bus_rdata[0] = ien_q;
            A_EVLO:   if (fifo_nempty) bus_rdata = head.ts;
            A_EVHI:   if (fifo_nempty) bus_rdata = hi_word(head);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tstamp_evt_unit_chk.sv
module tstamp_evt_unit_chk
    import tstamp_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             load,
    input logic [TS_W-1:0]  cnt,
    input logic [LVL_W-1:0] level,
    input logic             pop,
    input logic             ovf,
    input logic             ovf_clr,
    input logic             irq,
    input logic             nonempty
);
    a_r2_counts_up: assert property (@(posedge clk) disable iff (rst)
        (run && !load) |=> (cnt == $past(cnt) + 1'b1));

    a_r2_holds_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt));

    a_r12_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

    a_r13_no_growth_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |=> (level <= $past(level)));

    a_r10_pop_last: assert property (@(posedge clk) disable iff (rst)
        (pop && !run && level == LVL_W'(1)) |=> (level == '0));

    a_r11_irq_needs_entry: assert property (@(posedge clk) disable iff (rst)
        irq |-> nonempty);
endmodule

bind tstamp_evt_unit tstamp_evt_unit_chk #(.LVL_W(FLVL_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .load     (ld_req),
    .cnt      (cnt_q),
    .level    (fifo_level),
    .pop      (pop_req),
    .ovf      (ovf_q),
    .ovf_clr  (ovf_clr),
    .irq      (irq),
    .nonempty (fifo_nempty)
);

// File: tb/tstamp_evt_unit_tb_top.sv
module tstamp_evt_unit_tb_top;
    import tstamp_pkg::*;

    localparam int CLK_P = 10;
    localparam int QDEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  hw_stb = '0;
    logic        rx_stb = 1'b0, tx_stb = 1'b0;
    logic [3:0]  rx_msg = '0, tx_msg = '0;
    logic [15:0] rx_seq = '0, tx_seq = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    tstamp_evt_unit dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_stb(hw_stb),
        .rx_stb(rx_stb), .rx_msg(rx_msg), .rx_seq(rx_seq),
        .tx_stb(tx_stb), .tx_msg(tx_msg), .tx_seq(tx_seq), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [63:0] mq[$];
    logic [31:0] m_cnt, m_ld;
    logic        m_en, m_ie, m_ovf;
    int          m_st, m_acc;

    task automatic add_ev(input logic [31:0] hi, input logic [31:0] lo);
        if (m_st + m_acc < QDEPTH) begin
            mq.push_back({hi, lo});
            m_acc++;
        end else begin
            m_ovf = 1'b1;
        end
    endtask

    function automatic logic wr_is(input logic [7:0] a);
        return bus_wr && (bus_addr == a);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_cnt = '0; m_ld = '0; m_en = 1'b0; m_ie = 1'b0; m_ovf = 1'b0;
        end else begin
            logic ldr;
            ldr   = wr_is(A_LDEN) && bus_wdata[0];
            m_st  = mq.size();
            m_acc = 0;
            if (wr_is(A_RAW) && bus_wdata[1]) m_ovf = 1'b0;
            if (m_en) begin
                if (m_cnt == 32'hFFFF_FFFF && !ldr) add_ev(32'h0010_0000, 32'h0);
                if (m_cnt == 32'h7FFF_FFFF && !ldr) add_ev(32'h0020_0000, 32'h8000_0000);
                if (wr_is(A_PUSH) && bus_wdata[0]) add_ev(32'h0, m_cnt);
                for (int k = 0; k < 4; k++)
                    if (hw_stb[k]) add_ev({8'h0, 4'h3, 4'h0, 16'(k)}, m_cnt);
                if (rx_stb) add_ev({8'h0, 4'h4, rx_msg, rx_seq}, m_cnt);
                if (tx_stb) add_ev({8'h0, 4'h5, tx_msg, tx_seq}, m_cnt);
            end
            if (wr_is(A_POP) && bus_wdata[0] && m_st > 0) mq.delete(0);
            if (ldr) m_cnt = m_ld;
            else if (m_en) m_cnt = m_cnt + 1;
            if (wr_is(A_CTRL))  m_en = bus_wdata[0];
            if (wr_is(A_LDVAL)) m_ld = bus_wdata;
            if (wr_is(A_IEN))   m_ie = bus_wdata[0];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic fire(input logic [3:0] hw, input logic rx, input logic tx, input logic psh);
        @(negedge clk);
        hw_stb = hw; rx_stb = rx; tx_stb = tx;
        if (psh) begin bus_wr = 1'b1; bus_addr = A_PUSH; bus_wdata = 32'h1; end
        @(negedge clk);
        hw_stb = '0; rx_stb = 1'b0; tx_stb = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic vs_model(input string rq);
        logic [31:0] d;
        rd(A_EVLO, d);   chk(rq, d, mq.size() > 0 ? mq[0][31:0]  : 32'h0);
        rd(A_EVHI, d);   chk(rq, d, mq.size() > 0 ? mq[0][63:32] : 32'h0);
        rd(A_RAW, d);    chk(rq, d, {30'h0, m_ovf, mq.size() > 0});
        chk(rq, {31'h0, irq}, {31'h0, m_ie && mq.size() > 0});
    endtask

    task automatic drain;
        while (mq.size() > 0) wr(A_POP, 32'h1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] d, ts0;
        int npop;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and identification
        rd(A_ID, d);     chk("R1 id", d, 32'h4E8A0101);
        rd(A_CTRL, d);   chk("R1 ctrl reset", d, 32'h0);
        rd(8'h18, d);    chk("R1 reserved", d, 32'h0);
        rd(A_RAW, d);    chk("R9 raw reset", d, 32'h0);
        chk("R11 irq reset", {31'h0, irq}, 32'h0);
        wr(A_REFSEL, 32'h5); rd(A_REFSEL, d); chk("R1 refsel rw", d, 32'h5);

        // R13 nothing queues while stopped
        fire(4'hF, 1'b1, 1'b1, 1'b1);
        rd(A_RAW, d);    chk("R13 stopped no events", d, 32'h0);

        // R2 load while stopped, then run; R3 push
        wr(A_LDVAL, 32'h55); wr(A_LDEN, 32'h1);
        repeat (4) @(negedge clk);
        wr(A_CTRL, 32'h1);
        fire(4'h0, 1'b0, 1'b0, 1'b1);
        rd(A_EVLO, d);   chk("R2 load then count", d, 32'h56);
        rd(A_EVHI, d);   chk("R3 push kind", d, 32'h0);
        vs_model("R3 push model");
        drain();

        // R4 half wrap
        wr(A_LDVAL, 32'h7FFF_FFFD); wr(A_LDEN, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_EVHI, d);   chk("R4 half kind", d, 32'h0020_0000);
        rd(A_EVLO, d);   chk("R4 half ts", d, 32'h8000_0000);
        vs_model("R4 half model");
        drain();
        // R4 full wrap
        wr(A_LDVAL, 32'hFFFF_FFFD); wr(A_LDEN, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_EVHI, d);   chk("R4 wrap kind", d, 32'h0010_0000);
        rd(A_EVLO, d);   chk("R4 wrap ts", d, 32'h0);
        drain();

        // R8 same-cycle priority, R5 lanes, R6 rx/tx, R7 layout
        rx_msg = 4'hA; rx_seq = 16'h1234; tx_msg = 4'h3; tx_seq = 16'hBEEF;
        fire(4'hF, 1'b1, 1'b1, 1'b1);
        rd(A_EVLO, ts0);
        rd(A_EVHI, d); chk("R8 first push", d, 32'h0);
        for (int k = 0; k < 4; k++) begin
            wr(A_POP, 32'h1);
            rd(A_EVHI, d); chk("R5 lane descriptor", d, 32'h0030_0000 | k);
            rd(A_EVLO, d); chk("R5 lane ts", d, ts0);
        end
        wr(A_POP, 32'h1);
        rd(A_EVHI, d); chk("R6 rx descriptor R7", d, 32'h004A_1234);
        wr(A_POP, 32'h1);
        rd(A_EVHI, d); chk("R6 tx descriptor R7", d, 32'h0053_BEEF);
        rd(A_EVLO, d); chk("R6 tx ts", d, ts0);
        drain();

        // R11 interrupt gating
        fire(4'h1, 1'b0, 1'b0, 1'b0);
        chk("R11 irq masked off", {31'h0, irq}, 32'h0);
        rd(A_MASKED, d); chk("R11 masked off", d, 32'h0);
        wr(A_IEN, 32'h1);
        chk("R11 irq on", {31'h0, irq}, 32'h1);
        rd(A_MASKED, d); chk("R11 masked on", d, 32'h1);
        drain();
        chk("R11 irq after drain", {31'h0, irq}, 32'h0);

        // R12 overflow
        repeat (5) fire(4'hF, 1'b0, 1'b0, 1'b0);
        rd(A_RAW, d);    chk("R12 overflow set", d, 32'h3);
        vs_model("R12 full model");
        wr(A_RAW, 32'h2);
        rd(A_RAW, d);    chk("R12 overflow clear", d, 32'h1);
        @(negedge clk);
        hw_stb = 4'h1; bus_wr = 1'b1; bus_addr = A_POP; bus_wdata = 32'h1;
        @(negedge clk);
        hw_stb = '0; bus_wr = 1'b0;
        rd(A_RAW, d);    chk("R12 pop gives no room", d, 32'h3);
        npop = 0;
        rd(A_RAW, d);
        while (d[0] && npop < 40) begin
            wr(A_POP, 32'h1); npop++;
            rd(A_RAW, d);
        end
        chk("R12 kept entries", npop, 32'd15);
        wr(A_RAW, 32'h2);

        // R10 pop on empty, R9 empty reads
        wr(A_POP, 32'h1);
        rd(A_RAW, d);    chk("R10 pop empty", d, 32'h0);
        rd(A_EVLO, d);   chk("R9 empty low", d, 32'h0);
        rd(A_EVHI, d);   chk("R9 empty high", d, 32'h0);
        rx_msg = 4'h7; rx_seq = 16'h0042;
        fire(4'h0, 1'b1, 1'b0, 1'b0);
        rd(A_EVHI, d);   chk("R10 after empty pop", d, 32'h0047_0042);
        vs_model("R10 model");
        drain();

        // random phase
        wr(A_LDVAL, 32'hFFFF_FF80);
        for (int it = 0; it < 600; it++) begin
            vs_model("R9 random");
            @(negedge clk);
            hw_stb = '0; rx_stb = 1'b0; tx_stb = 1'b0; bus_wr = 1'b0;
            hw_stb = 4'($urandom) & 4'($urandom) & 4'($urandom);
            rx_stb = ($urandom % 5) == 0; rx_msg = 4'($urandom); rx_seq = 16'($urandom);
            tx_stb = ($urandom % 5) == 0; tx_msg = 4'($urandom); tx_seq = 16'($urandom);
            case ($urandom % 20)
                0, 1, 2, 3, 4, 5, 6, 7: begin bus_wr = 1'b1; bus_addr = A_POP;  bus_wdata = 32'h1; end
                8, 9:  begin bus_wr = 1'b1; bus_addr = A_PUSH; bus_wdata = 32'h1; end
                10:    begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = {31'h0, ($urandom % 4) != 0}; end
                11:    begin bus_wr = 1'b1; bus_addr = A_LDEN; bus_wdata = 32'h1; end
                12:    begin bus_wr = 1'b1; bus_addr = A_RAW;  bus_wdata = 32'h2; end
                13:    begin bus_wr = 1'b1; bus_addr = A_LDVAL; bus_wdata = (($urandom % 2) != 0) ? 32'h7FFF_FFC0 : 32'hFFFF_FFC0; end
                default: ;
            endcase
            @(negedge clk);
            hw_stb = '0; rx_stb = 1'b0; tx_stb = 1'b0; bus_wr = 1'b0;
        end
        vs_model("R12 random end");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule